// File: doc/BRIEF.md
# Coarse-Fine Amplitude and Keyed Level Controller

This block converts a requested peak-to-peak output amplitude, given in millivolts, into two settings for an analog output chain. The first is a 3-bit coarse attenuator select, where each step halves the voltage (0 dB down to -42 dB). The second is a 12-bit fine level, which the block delivers both as a registered duty word and as a PWM waveform. That waveform is filtered downstream into the reference voltage of the DAC. The block picks the coarse step so that the fine level sits in the upper half of its range whenever attenuation is still available. This keeps the fine control at good resolution and gives more than 70 dB of combined range.

An amplitude-keying overlay supports a time-code carrier whose level follows a serial data bit. When keying is enabled and the key input is low, the fine level drops to one eighth of its programmed value. The attenuator select and the fine level change only at the start of a PWM period, and always together, so the output never passes through a mixed setting.

Top module: `amp_level_ctl`

## Requirements
- R1: While reset is high, att_sel is 7 (maximum attenuation), duty_now is 0, and pwm_out and period_tick are low.
- R2: After clamping the request to 20000 mV, the coarse step n is the largest value in 0..7 for which request × 2^n ≤ 20000. For example, 10000 mV gives step 1, 1234 mV gives step 4, and 10 mV gives step 7.
- R3: The fine duty is floor((4095 × request × 2^n + 10000) / 20000), which rounds half up. For example, 15000 mV gives 3071 and 7000 mV gives 2867.
- R4: A request above 20000 mV gives step 0 and duty 4095. A request of 0 gives step 7 and duty 0.
- R5: Whenever the step is below 7 and keying is not reducing the level, duty_now is at least 2048.
- R6: The PWM period is 4096 clocks. period_tick is high only in the first clock of each period. Within a period, pwm_out is high for exactly duty_now clocks, starting at the first clock.
- R7: att_sel and duty_now change only in the cycle where period_tick is high, and both take values from the same request. A request written in the last two clocks of a period takes effect one period later.
- R8: When ask_en is 1 and ask_key is 0 at the start of a period, duty_now for that period is the programmed duty shifted right by 3. att_sel is not affected.
- R9: Changes to ask_en and ask_key in the middle of a period have no effect until the next period starts.
- R10: When ask_en is 0, ask_key has no effect on duty_now or pwm_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| amp_wr | input | 1 | Strobe that accepts amp_mv |
| amp_mv | input | 15 | Requested amplitude in mV peak-to-peak |
| ask_en | input | 1 | Enables amplitude keying |
| ask_key | input | 1 | Keying bit, where low means reduced level |
| att_sel | output | 3 | Coarse attenuator select, 6 dB per step |
| duty_now | output | 12 | Fine duty in force for the current period |
| pwm_out | output | 1 | Fine-level PWM waveform |
| period_tick | output | 1 | High in the first clock of each PWM period |

## Verification
Two things can land on the same period boundary: a newly computed amplitude pair (step and duty) and a change in the keying state. The bench writes a new amplitude and lowers the key in the same period. It then expects the next period to show the new step together with the new duty shifted right by 3, all in the one cycle where period_tick is high. A second case writes an amplitude two clocks before a wrap. Here the bench requires that both att_sel and duty_now keep their old values for one more full period and then switch together.

// File: rtl/amp_ctl_pkg.sv
package amp_ctl_pkg;
  localparam int DEF_CNT_W     = 12;
  localparam int DEF_SEL_W     = 3;
  localparam int DEF_AMP_W     = 15;
  localparam int DEF_FULL_MV   = 20000;
  localparam int DEF_ASK_SHIFT = 3;

  typedef enum logic {
    LVL_FULL = 1'b0,
    LVL_CUT  = 1'b1
  } key_lvl_e;
endpackage

// File: rtl/amp_coarse_sel.sv
module amp_coarse_sel #(
  parameter int AMP_W   = amp_ctl_pkg::DEF_AMP_W,
  parameter int SEL_W   = amp_ctl_pkg::DEF_SEL_W,
  parameter int FULL_MV = amp_ctl_pkg::DEF_FULL_MV,
  localparam int STEPS  = 2 ** SEL_W,
  localparam int SCL_W  = AMP_W + STEPS - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [AMP_W-1:0] req_mv,
  output logic             s1_valid,
  output logic [SEL_W-1:0] s1_sel,
  output logic [SCL_W-1:0] s1_scaled
);
  localparam logic [AMP_W-1:0] FULL_A = AMP_W'(FULL_MV);
  localparam logic [SCL_W-1:0] FULL_S = SCL_W'(FULL_MV);

  logic [AMP_W-1:0] req_c;
  logic [SCL_W-1:0] req_ext;
  logic [STEPS-1:0] fits;
  logic [SEL_W-1:0] sel_c;
  logic [SCL_W-1:0] scaled_c;

  assign req_c   = (req_mv > FULL_A) ? FULL_A : req_mv;
  assign req_ext = SCL_W'(req_c);

  // one comparator per attenuation step
  for (genvar n = 0; n < STEPS; n++) begin : g_fit
    assign fits[n] = (req_ext << n) <= FULL_S;
  end

  always_comb begin
    sel_c = '0;
    for (int n = 0; n < STEPS; n++) begin
      if (fits[n]) sel_c = SEL_W'(n);
    end
    scaled_c = req_ext << sel_c;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_sel    <= '1;
      s1_scaled <= '0;
    end else begin
      s1_valid <= req_valid;
      if (req_valid) begin
        s1_sel    <= sel_c;
        s1_scaled <= scaled_c;
      end
    end
  end
endmodule

// File: rtl/amp_duty_scale.sv
module amp_duty_scale #(
  parameter int CNT_W   = amp_ctl_pkg::DEF_CNT_W,
  parameter int SEL_W   = amp_ctl_pkg::DEF_SEL_W,
  parameter int SCL_W   = 22,
  parameter int FULL_MV = amp_ctl_pkg::DEF_FULL_MV,
  localparam int PROD_W = SCL_W + CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s1_valid,
  input  logic [SEL_W-1:0] s1_sel,
  input  logic [SCL_W-1:0] s1_scaled,
  output logic [SEL_W-1:0] pend_sel,
  output logic [CNT_W-1:0] pend_duty
);
  localparam logic [PROD_W-1:0] MAXD_P = PROD_W'((2 ** CNT_W) - 1);
  localparam logic [PROD_W-1:0] FULL_P = PROD_W'(FULL_MV);
  localparam logic [PROD_W-1:0] HALF_P = PROD_W'(FULL_MV / 2);

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] quot;
  logic [CNT_W-1:0]  duty_c;

  assign prod   = PROD_W'(s1_scaled) * MAXD_P + HALF_P;
  assign quot   = prod / FULL_P;
  assign duty_c = (quot > MAXD_P) ? '1 : quot[CNT_W-1:0];

  // step and duty are written in the same cycle so they stay paired
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_sel  <= '1;
      pend_duty <= '0;
    end else if (s1_valid) begin
      pend_sel  <= s1_sel;
      pend_duty <= duty_c;
    end
  end
endmodule

// File: rtl/amp_pwm_core.sv
module amp_pwm_core
  import amp_ctl_pkg::*;
#(
  parameter int CNT_W     = DEF_CNT_W,
  parameter int SEL_W     = DEF_SEL_W,
  parameter int ASK_SHIFT = DEF_ASK_SHIFT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] pend_sel,
  input  logic [CNT_W-1:0] pend_duty,
  input  logic             ask_en,
  input  logic             ask_key,
  output logic [SEL_W-1:0] att_sel,
  output logic [CNT_W-1:0] duty_now,
  output logic             pwm_out,
  output logic             period_tick,
  output logic             cut_active
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             wrap;
  logic             cut_c;
  logic [CNT_W-1:0] eff_duty;
  logic [CNT_W-1:0] duty_nx;
  key_lvl_e         lvl_q;

  assign wrap     = (cnt_q == '1);
  assign cnt_d    = cnt_q + 1'b1;
  assign cut_c    = ask_en & ~ask_key;
  assign eff_duty = cut_c ? (pend_duty >> ASK_SHIFT) : pend_duty;
  assign duty_nx  = wrap ? eff_duty : duty_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q       <= '0;
      att_sel     <= '1;
      duty_now    <= '0;
      pwm_out     <= 1'b0;
      period_tick <= 1'b0;
      lvl_q       <= LVL_FULL;
    end else begin
      cnt_q       <= cnt_d;
      period_tick <= wrap;
      pwm_out     <= (cnt_d < duty_nx);
      if (wrap) begin
        att_sel  <= pend_sel;
        duty_now <= eff_duty;
        lvl_q    <= cut_c ? LVL_CUT : LVL_FULL;
      end
    end
  end

  assign cut_active = (lvl_q == LVL_CUT);
endmodule

// File: rtl/amp_level_ctl.sv
module amp_level_ctl #(
  parameter int CNT_W     = amp_ctl_pkg::DEF_CNT_W,
  parameter int SEL_W     = amp_ctl_pkg::DEF_SEL_W,
  parameter int AMP_W     = amp_ctl_pkg::DEF_AMP_W,
  parameter int FULL_MV   = amp_ctl_pkg::DEF_FULL_MV,
  parameter int ASK_SHIFT = amp_ctl_pkg::DEF_ASK_SHIFT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             amp_wr,
  input  logic [AMP_W-1:0] amp_mv,
  input  logic             ask_en,
  input  logic             ask_key,
  output logic [SEL_W-1:0] att_sel,
  output logic [CNT_W-1:0] duty_now,
  output logic             pwm_out,
  output logic             period_tick
);
  localparam int SCL_W = AMP_W + (2 ** SEL_W) - 1;

  logic             s1_valid;
  logic [SEL_W-1:0] s1_sel;
  logic [SCL_W-1:0] s1_scaled;
  logic [SEL_W-1:0] pend_sel;
  logic [CNT_W-1:0] pend_duty;
  logic             cut_q;

  amp_coarse_sel #(.AMP_W(AMP_W), .SEL_W(SEL_W), .FULL_MV(FULL_MV)) sel_i (
    .clk(clk), .rst(rst), .req_valid(amp_wr), .req_mv(amp_mv),
    .s1_valid(s1_valid), .s1_sel(s1_sel), .s1_scaled(s1_scaled)
  );

  amp_duty_scale #(.CNT_W(CNT_W), .SEL_W(SEL_W), .SCL_W(SCL_W), .FULL_MV(FULL_MV)) scale_i (
    .clk(clk), .rst(rst), .s1_valid(s1_valid), .s1_sel(s1_sel),
    .s1_scaled(s1_scaled), .pend_sel(pend_sel), .pend_duty(pend_duty)
  );

  amp_pwm_core #(.CNT_W(CNT_W), .SEL_W(SEL_W), .ASK_SHIFT(ASK_SHIFT)) pwm_i (
    .clk(clk), .rst(rst), .pend_sel(pend_sel), .pend_duty(pend_duty),
    .ask_en(ask_en), .ask_key(ask_key), .att_sel(att_sel),
    .duty_now(duty_now), .pwm_out(pwm_out), .period_tick(period_tick),
    .cut_active(cut_q)
  );
endmodule

// File: rtl/amp_level_ctl_chk.sv
module amp_level_ctl_chk #(
  parameter int CNT_W     = 12,
  parameter int SEL_W     = 3,
  parameter int ASK_SHIFT = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [SEL_W-1:0] att_sel,
  input logic [CNT_W-1:0] duty_now,
  input logic             pwm_out,
  input logic             period_tick,
  input logic             cut_active
);
  localparam logic [CNT_W-1:0] HALF_D = CNT_W'(2 ** (CNT_W - 1));
  localparam logic [CNT_W-1:0] CUT_MAX = CNT_W'(((2 ** CNT_W) - 1) >> ASK_SHIFT);

  assert_hold_midperiod_R7: assert property (@(posedge clk) disable iff (rst)
    !period_tick |-> ($stable(att_sel) && $stable(duty_now)));

  assert_half_scale_R5: assert property (@(posedge clk) disable iff (rst)
    (att_sel != '1 && !cut_active) |-> duty_now >= HALF_D);

  assert_cut_ceiling_R8: assert property (@(posedge clk) disable iff (rst)
    cut_active |-> duty_now <= CUT_MAX);

  assert_tick_single_R6: assert property (@(posedge clk) disable iff (rst)
    period_tick |=> !period_tick);

  assert_pwm_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (duty_now == '0) |-> !pwm_out);

  assert_pwm_head_R6: assert property (@(posedge clk) disable iff (rst)
    (period_tick && duty_now != '0) |-> pwm_out);
endmodule

bind amp_level_ctl amp_level_ctl_chk #(
  .CNT_W(CNT_W), .SEL_W(SEL_W), .ASK_SHIFT(ASK_SHIFT)
) chk_i (
  .clk(clk), .rst(rst), .att_sel(att_sel), .duty_now(duty_now),
  .pwm_out(pwm_out), .period_tick(period_tick), .cut_active(cut_q)
);

// File: tb/amp_level_ctl_tb_top.sv
module amp_level_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PER = 4096;
  localparam int NV = 13;
  localparam int VEC_MV  [NV] = '{20000, 15000, 10000, 10010, 5000, 7000, 1234,
                                  10, 156, 157, 25000, 0, 2500};
  localparam int VEC_SEL [NV] = '{0, 0, 1, 0, 2, 1, 4, 7, 7, 6, 0, 7, 3};
  localparam int VEC_DUTY[NV] = '{4095, 3071, 4095, 2050, 4095, 2867, 4043,
                                  262, 4088, 2057, 4095, 0, 4095};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        amp_wr = 1'b0;
  logic [14:0] amp_mv = '0;
  logic        ask_en = 1'b0;
  logic        ask_key = 1'b1;
  logic [2:0]  att_sel;
  logic [11:0] duty_now;
  logic        pwm_out;
  logic        period_tick;

  int nchk = 0;
  int nfail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  amp_level_ctl dut_i (
    .clk(clk), .rst(rst), .amp_wr(amp_wr), .amp_mv(amp_mv),
    .ask_en(ask_en), .ask_key(ask_key), .att_sel(att_sel),
    .duty_now(duty_now), .pwm_out(pwm_out), .period_tick(period_tick)
  );

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (period_tick !== 1'b1);
  endtask

  task automatic write_amp(input int mv);
    amp_mv = 15'(mv);
    amp_wr = 1'b1;
    @(negedge clk);
    amp_wr = 1'b0;
  endtask

  // called at a tick cycle; counts pwm highs over the whole period
  task automatic measure(output int highs, input int flip_at, input logic flip_val);
    highs = 0;
    for (int i = 0; i < PER; i++) begin
      if (i > 0) @(negedge clk);
      if (i == flip_at) ask_key = flip_val;
      if (pwm_out) highs++;
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int highs;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 att_sel", att_sel, 7);
    check("R1 duty_now", duty_now, 0);
    check("R1 pwm_out", pwm_out, 0);
    check("R1 period_tick", period_tick, 0);
    rst = 1'b0;

    // R2 R3 R4 R5 R6: vector table
    for (int v = 0; v < NV; v++) begin
      wait_tick();
      write_amp(VEC_MV[v]);
      wait_tick();
      check($sformatf("R2 step mv=%0d", VEC_MV[v]), att_sel, VEC_SEL[v]);
      check($sformatf("R3 R4 duty mv=%0d", VEC_MV[v]), duty_now, VEC_DUTY[v]);
      measure(highs, -1, 1'b1);
      check($sformatf("R6 pwm highs mv=%0d", VEC_MV[v]), highs, VEC_DUTY[v]);
    end

    // R8: keyed low reduces duty, step unchanged
    wait_tick();
    write_amp(15000);
    ask_en = 1'b1;
    ask_key = 1'b0;
    wait_tick();
    check("R8 cut duty", duty_now, 3071 >> 3);
    check("R8 step kept", att_sel, 0);
    // R9: key raised mid-period must not alter this period
    measure(highs, 2000, 1'b1);
    check("R9 mid-period key ignored", highs, 3071 >> 3);
    wait_tick();
    check("R9 key applied next period", duty_now, 3071);

    // R10: keying disabled, key low has no effect
    ask_en = 1'b0;
    ask_key = 1'b0;
    wait_tick();
    check("R10 key ignored duty", duty_now, 3071);
    measure(highs, -1, 1'b0);
    check("R10 key ignored pwm", highs, 3071);

    // R7: write two clocks before wrap lands one period late, as a pair
    wait_tick();
    repeat (PER - 2) @(negedge clk);
    write_amp(10000);
    check("R7 no tick yet", period_tick, 0);
    wait_tick();
    check("R7 late write old step", att_sel, 0);
    check("R7 late write old duty", duty_now, 3071);
    wait_tick();
    check("R7 late write new step", att_sel, 1);
    check("R7 late write new duty", duty_now, 4095);

    // R7 R8: new amplitude and keying change in the same period
    ask_en = 1'b1;
    ask_key = 1'b0;
    write_amp(5000);
    check("R7 held mid-period step", att_sel, 1);
    check("R7 held mid-period duty", duty_now, 4095);
    wait_tick();
    check("R7 joint step", att_sel, 2);
    check("R8 joint cut duty", duty_now, 4095 >> 3);
    measure(highs, -1, 1'b0);
    check("R6 R8 joint pwm highs", highs, 511);

    finish_run();
  end
endmodule